// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and the main decoder of a 32-bit RISC-V core. It takes a 32-bit fetch word and looks at its two lowest bits. If the word holds a 16-bit compressed instruction in its lower half, the block rewrites it into the equivalent full-width base instruction. The core's existing 32-bit decoder then handles it with no compressed-specific logic. If the word is already a full instruction, the block passes it through untouched.

The block is purely combinational and has no clock. A result is valid in the same cycle as the word that produced it. The supported compressed set is:

- immediate add
- word load and store relative to the stack pointer
- word load and store through a register
- register-register subtract, xor, or and and
- the six control transfers

Any other 16-bit pattern, and any reserved form of a supported one, raises the illegal flag and yields an all-zero word.

A valid strobe qualifies the input. While the strobe is low, every output is held at zero so that downstream logic sees no stray instruction. The block has no back-pressure of its own: the strobe is a qualifier only, and any stall is handled by the stage that owns the fetch word.

Top module: `cx_expand`

## Requirements
- R1: A 3-bit compressed register field with value n names register x(8+n); field value 3'b100 names x12.
- R2: Quadrant 01, funct3 [15:13]=000 (immediate add) expands to addi with rd=rs1=bits[11:7] and a 12-bit immediate sign-extended from {bit12, bits[6:2]}. A zero register field or a zero immediate is reserved and flagged illegal.
- R3: Quadrant 10, funct3=010 (stack load) expands to lw rd,off(x2) with rd=bits[11:7] and off = {bits[3:2], bit12, bits[6:4], 2'b00}, zero-extended. rd=0 is flagged illegal.
- R4: Quadrant 10, funct3=110 (stack store) expands to sw rs2,off(x2) with rs2=bits[6:2] and off = {bits[8:7], bits[12:9], 2'b00}, zero-extended.
- R5: Quadrant 00, funct3=010 (load) and 110 (store) expand to lw or sw with base x(8+bits[9:7]) and data register x(8+bits[4:2]). The offset is {bit5, bits[12:10], bit6, 2'b00}, zero-extended.
- R6: Quadrant 01, funct3=100, bit12=0, bits[11:10]=11 expands to an R-type with rd=rs1=x(8+bits[9:7]) and rs2=x(8+bits[4:2]). bits[6:5] select 00 sub, 01 xor, 10 or, 11 and. Every other quadrant-01 funct3=100 pattern is illegal.
- R7: Quadrant 01, funct3 101 (jump) and 001 (jump-and-link) expand to jal with rd=x0 and rd=x1 respectively. The offset is sign-extended from bit12 and assembled as off[11]=b12, off[10]=b8, off[9:8]=b[10:9], off[7]=b6, off[6]=b7, off[5]=b2, off[4]=b11, off[3:1]=b[5:3], off[0]=0.
- R8: Quadrant 10, funct3=100 with bits[6:2]=0 and rs1=bits[11:7] nonzero expands to jalr rd,0(rs1): rd=x0 when bit12=0, rd=x1 when bit12=1. With rs1=0, or with bits[6:2] nonzero, the word is illegal.
- R9: Quadrant 01, funct3 110 and 111 expand to beq and bne with rs1=x(8+bits[9:7]) and rs2=x0. The offset is sign-extended from bit12 and assembled as off[8]=b12, off[7:6]=b[6:5], off[5]=b2, off[4:3]=b[11:10], off[2:1]=b[4:3], off[0]=0.
- R10: With valid high and bits[1:0]=11, the output word equals the input word, the compressed flag is low and the illegal flag is low.
- R11: An all-zero lower half, and every compressed pattern outside R2-R9's legal forms, gives illegal=1, compressed=1 and an all-zero output word.
- R12: For a compressed input, bits[31:16] of the fetch word have no effect on any output.
- R13: With valid low, the output word and both flags are zero, whatever the fetch word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vld_i | input | 1 | Fetch word qualifier |
| fetch_i | input | 32 | Fetch word; a compressed instruction occupies bits [15:0] |
| instr_o | output | 32 | Expanded or passed-through base instruction, zero when illegal or not valid |
| is_comp_o | output | 1 | High when the valid word was a 16-bit form |
| illegal_o | output | 1 | High when the valid 16-bit form is reserved or unsupported |

## Verification
Every output is a function of the current inputs only, so each result is due in the same cycle as its stimulus, with zero register stages. The bench changes the inputs just after a falling clock edge and reads the outputs just before the next rising edge, half a period later. This leaves the comparison clear of any edge ordering. No check ever waits on an earlier stimulus, so each comparison depends only on the word driven in that same half-cycle.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int ILEN = 32;
  localparam int CLEN = 16;
  localparam int RIDX = 5;
  localparam int CRIDX = 3;

  typedef enum logic [1:0] {
    QD_MEM  = 2'b00,
    QD_ARJ  = 2'b01,
    QD_STK  = 2'b10,
    QD_FULL = 2'b11
  } quad_e;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_WORD = 3'b010;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_AND  = 3'b111;
  localparam logic [2:0] F3_BEQ  = 3'b000;
  localparam logic [2:0] F3_BNE  = 3'b001;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  localparam logic [RIDX-1:0] REG_ZERO = 5'd0;
  localparam logic [RIDX-1:0] REG_LINK = 5'd1;
  localparam logic [RIDX-1:0] REG_SP   = 5'd2;

  // short register field n selects x(8+n)
  function automatic logic [RIDX-1:0] widen_reg(input logic [CRIDX-1:0] c);
    return {2'b01, c};
  endfunction
endpackage

// File: rtl/cx_q0_mem.sv
module cx_q0_mem
  import cx_pkg::*;
(
  input  logic [CLEN-1:0] half_i,
  output logic [ILEN-1:0] word_o,
  output logic            bad_o
);
  logic [2:0]      f3;
  logic [RIDX-1:0] base_r;
  logic [RIDX-1:0] data_r;
  logic [11:0]     ld_imm;
  logic [6:0]      st_hi;
  logic [4:0]      st_lo;

  assign f3     = half_i[15:13];
  assign base_r = widen_reg(half_i[9:7]);
  assign data_r = widen_reg(half_i[4:2]);
  assign ld_imm = {5'b0, half_i[5], half_i[12], half_i[11], half_i[10], half_i[6], 2'b00};
  assign st_hi  = {5'b0, half_i[5], half_i[12]};
  assign st_lo  = {half_i[11], half_i[10], half_i[6], 2'b00};

  always_comb begin
    word_o = '0;
    bad_o  = 1'b1;
    if (half_i[1:0] == QD_MEM) begin
      unique case (f3)
        3'b010: begin
          word_o = {ld_imm, base_r, F3_WORD, data_r, OPC_LOAD};
          bad_o  = 1'b0;
        end
        3'b110: begin
          word_o = {st_hi, data_r, base_r, F3_WORD, st_lo, OPC_STORE};
          bad_o  = 1'b0;
        end
        default: begin
          word_o = '0;
          bad_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/cx_q1_arj.sv
module cx_q1_arj
  import cx_pkg::*;
(
  input  logic [CLEN-1:0] half_i,
  output logic [ILEN-1:0] word_o,
  output logic            bad_o
);
  logic [2:0]      f3;
  logic [RIDX-1:0] full_rd;
  logic [RIDX-1:0] sh_a;
  logic [RIDX-1:0] sh_b;
  logic            sgn;
  logic [5:0]      imm6;
  logic [11:0]     addi_imm;
  logic [19:0]     jal_imm;
  logic [6:0]      br_hi;
  logic [4:0]      br_lo;
  logic [2:0]      alu_f3;
  logic [6:0]      alu_f7;
  logic            alu_ok;

  assign f3      = half_i[15:13];
  assign full_rd = half_i[11:7];
  assign sh_a    = widen_reg(half_i[9:7]);
  assign sh_b    = widen_reg(half_i[4:2]);
  assign sgn     = half_i[12];
  assign imm6    = {half_i[12], half_i[6:2]};
  assign addi_imm = {{6{sgn}}, imm6};

  // jal field order: imm[20], imm[10:1], imm[11], imm[19:12]
  assign jal_imm = {sgn,
                    half_i[8], half_i[10], half_i[9], half_i[6], half_i[7],
                    half_i[2], half_i[11], half_i[5], half_i[4], half_i[3],
                    sgn,
                    {8{sgn}}};

  // branch fields: imm[12], imm[10:5] then imm[4:1], imm[11]
  assign br_hi = {sgn, sgn, sgn, sgn, half_i[6], half_i[5], half_i[2]};
  assign br_lo = {half_i[11], half_i[10], half_i[4], half_i[3], sgn};

  always_comb begin
    alu_f3 = F3_ADD;
    alu_f7 = F7_BASE;
    unique case (half_i[6:5])
      2'b00: begin alu_f3 = F3_ADD; alu_f7 = F7_ALT;  end
      2'b01: begin alu_f3 = F3_XOR; alu_f7 = F7_BASE; end
      2'b10: begin alu_f3 = F3_OR;  alu_f7 = F7_BASE; end
      default: begin alu_f3 = F3_AND; alu_f7 = F7_BASE; end
    endcase
  end

  assign alu_ok = !half_i[12] && (half_i[11:10] == 2'b11);

  always_comb begin
    word_o = '0;
    bad_o  = 1'b1;
    if (half_i[1:0] == QD_ARJ) begin
      unique case (f3)
        3'b000: begin
          if ((full_rd != REG_ZERO) && (imm6 != 6'd0)) begin
            word_o = {addi_imm, full_rd, F3_ADD, full_rd, OPC_OPIMM};
            bad_o  = 1'b0;
          end
        end
        3'b001: begin
          word_o = {jal_imm, REG_LINK, OPC_JAL};
          bad_o  = 1'b0;
        end
        3'b101: begin
          word_o = {jal_imm, REG_ZERO, OPC_JAL};
          bad_o  = 1'b0;
        end
        3'b100: begin
          if (alu_ok) begin
            word_o = {alu_f7, sh_b, sh_a, alu_f3, sh_a, OPC_OP};
            bad_o  = 1'b0;
          end
        end
        3'b110: begin
          word_o = {br_hi, REG_ZERO, sh_a, F3_BEQ, br_lo, OPC_BRANCH};
          bad_o  = 1'b0;
        end
        3'b111: begin
          word_o = {br_hi, REG_ZERO, sh_a, F3_BNE, br_lo, OPC_BRANCH};
          bad_o  = 1'b0;
        end
        default: begin
          word_o = '0;
          bad_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/cx_q2_stk.sv
module cx_q2_stk
  import cx_pkg::*;
(
  input  logic [CLEN-1:0] half_i,
  output logic [ILEN-1:0] word_o,
  output logic            bad_o
);
  logic [2:0]      f3;
  logic [RIDX-1:0] r_hi;
  logic [RIDX-1:0] r_lo;
  logic [11:0]     lsp_imm;
  logic [6:0]      ssp_hi;
  logic [4:0]      ssp_lo;

  assign f3      = half_i[15:13];
  assign r_hi    = half_i[11:7];
  assign r_lo    = half_i[6:2];
  assign lsp_imm = {4'b0, half_i[3], half_i[2], half_i[12], half_i[6], half_i[5], half_i[4], 2'b00};
  assign ssp_hi  = {4'b0, half_i[8], half_i[7], half_i[12]};
  assign ssp_lo  = {half_i[11], half_i[10], half_i[9], 2'b00};

  always_comb begin
    word_o = '0;
    bad_o  = 1'b1;
    if (half_i[1:0] == QD_STK) begin
      unique case (f3)
        3'b010: begin
          if (r_hi != REG_ZERO) begin
            word_o = {lsp_imm, REG_SP, F3_WORD, r_hi, OPC_LOAD};
            bad_o  = 1'b0;
          end
        end
        3'b110: begin
          word_o = {ssp_hi, r_lo, REG_SP, F3_WORD, ssp_lo, OPC_STORE};
          bad_o  = 1'b0;
        end
        3'b100: begin
          if ((r_lo == REG_ZERO) && (r_hi != REG_ZERO)) begin
            word_o = {12'd0, r_hi, F3_ADD, (half_i[12] ? REG_LINK : REG_ZERO), OPC_JALR};
            bad_o  = 1'b0;
          end
        end
        default: begin
          word_o = '0;
          bad_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/cx_expand.sv
module cx_expand
  import cx_pkg::*;
(
  input  logic            vld_i,
  input  logic [ILEN-1:0] fetch_i,
  output logic [ILEN-1:0] instr_o,
  output logic            is_comp_o,
  output logic            illegal_o
);
  logic [CLEN-1:0] half;
  logic [ILEN-1:0] w0, w1, w2;
  logic            b0, b1, b2;
  quad_e           quad;

  assign half = fetch_i[CLEN-1:0];
  assign quad = quad_e'(fetch_i[1:0]);

  cx_q0_mem u_q0 (.half_i(half), .word_o(w0), .bad_o(b0));
  cx_q1_arj u_q1 (.half_i(half), .word_o(w1), .bad_o(b1));
  cx_q2_stk u_q2 (.half_i(half), .word_o(w2), .bad_o(b2));

  always_comb begin
    instr_o   = '0;
    is_comp_o = 1'b0;
    illegal_o = 1'b0;
    if (vld_i) begin
      unique case (quad)
        QD_MEM:  begin instr_o = w0; is_comp_o = 1'b1; illegal_o = b0; end
        QD_ARJ:  begin instr_o = w1; is_comp_o = 1'b1; illegal_o = b1; end
        QD_STK:  begin instr_o = w2; is_comp_o = 1'b1; illegal_o = b2; end
        default: begin instr_o = fetch_i; is_comp_o = 1'b0; illegal_o = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/cx_expand_chk.sv
module cx_expand_chk
  import cx_pkg::*;
(
  input logic            vld_i,
  input logic [ILEN-1:0] fetch_i,
  input logic [ILEN-1:0] instr_o,
  input logic            is_comp_o,
  input logic            illegal_o
);
  always_comb begin
    if (vld_i === 1'b0) begin
      // R13
      idle_zero_chk: assert (instr_o == '0 && !is_comp_o && !illegal_o)
        else $error("outputs not idle while strobe low");
    end
    if (vld_i === 1'b1 && !$isunknown(fetch_i)) begin
      if (fetch_i[1:0] == 2'b11) begin
        // R10
        pass_thru_chk: assert (instr_o == fetch_i && !is_comp_o && !illegal_o)
          else $error("full-width word altered");
      end else begin
        // R11
        comp_flag_chk: assert (is_comp_o)
          else $error("compressed flag low on short form");
        if (fetch_i[15:0] == 16'd0) begin
          // R11
          zero_half_chk: assert (illegal_o)
            else $error("all-zero half accepted");
        end
        if (illegal_o) begin
          // R11
          bad_zero_chk: assert (instr_o == '0)
            else $error("illegal form left a nonzero word");
        end else begin
          // R11
          full_opc_chk: assert (instr_o[1:0] == 2'b11)
            else $error("expanded word not full width");
        end
        if (!illegal_o && instr_o[6:0] == OPC_OP) begin
          // R6
          alu_tied_chk: assert (instr_o[19:15] == instr_o[11:7] && instr_o[19:18] == 2'b01)
            else $error("arith form rd differs from rs1");
        end
        if (!illegal_o && instr_o[6:0] == OPC_OPIMM) begin
          // R2
          addi_tied_chk: assert (instr_o[19:15] == instr_o[11:7] && instr_o[11:7] != 5'd0)
            else $error("immediate add rd differs from rs1");
        end
      end
    end
  end
endmodule

bind cx_expand cx_expand_chk u_chk (
  .vld_i(vld_i),
  .fetch_i(fetch_i),
  .instr_o(instr_o),
  .is_comp_o(is_comp_o),
  .illegal_o(illegal_o)
);

// File: tb/cx_expand_tb.sv
module cx_expand_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 3000;
  localparam int WATCHDOG_CYC = 20000;

  typedef struct packed {
    logic [31:0] w;
    logic        c;
    logic        ill;
  } res_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [31:0] fetch_i = '0;
  logic [31:0] instr_o;
  logic        is_comp_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cx_expand u_dut (
    .vld_i(vld_i),
    .fetch_i(fetch_i),
    .instr_o(instr_o),
    .is_comp_o(is_comp_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                         logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                         logic [2:0] f3, logic [6:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction

  function automatic logic [31:0] enc_b(logic [12:0] imm, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction

  function automatic logic [31:0] enc_j(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6f};
  endfunction

  function automatic res_t model(logic v, logic [31:0] f);
    res_t r;
    logic [15:0] h;
    logic [31:0] off;
    logic [4:0]  a, b;
    logic [2:0]  f3;
    logic [6:0]  f7;
    r = '0;
    h = f[15:0];
    if (!v) return r;
    if (f[1:0] == 2'b11) begin
      r.w = f;
      return r;
    end
    r.c = 1'b1;
    r.ill = 1'b1;
    a = 5'd8 + {2'b00, h[9:7]};
    b = 5'd8 + {2'b00, h[4:2]};
    case ({h[15:13], h[1:0]})
      5'b010_00: begin
        off = {25'd0, h[5], h[12:10], h[6], 2'b00};
        r.w = enc_i(off[11:0], a, 3'd2, b, 7'h03); r.ill = 1'b0;
      end
      5'b110_00: begin
        off = {25'd0, h[5], h[12:10], h[6], 2'b00};
        r.w = enc_s(off[11:0], b, a, 3'd2, 7'h23); r.ill = 1'b0;
      end
      5'b000_01: begin
        off = {{26{h[12]}}, h[12], h[6:2]};
        if (h[11:7] != 5'd0 && off != 32'd0) begin
          r.w = enc_i(off[11:0], h[11:7], 3'd0, h[11:7], 7'h13); r.ill = 1'b0;
        end
      end
      5'b001_01, 5'b101_01: begin
        off = {{20{h[12]}}, h[12], h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3], 1'b0};
        r.w = enc_j(off[20:0], h[15] ? 5'd0 : 5'd1); r.ill = 1'b0;
      end
      5'b100_01: begin
        if (!h[12] && h[11:10] == 2'b11) begin
          f7 = 7'h00;
          case (h[6:5])
            2'b00: begin f3 = 3'd0; f7 = 7'h20; end
            2'b01: f3 = 3'd4;
            2'b10: f3 = 3'd6;
            default: f3 = 3'd7;
          endcase
          r.w = {f7, b, a, f3, a, 7'h33}; r.ill = 1'b0;
        end
      end
      5'b110_01, 5'b111_01: begin
        off = {{23{h[12]}}, h[12], h[6:5], h[2], h[11:10], h[4:3], 1'b0};
        r.w = enc_b(off[12:0], a, h[13] ? 3'd1 : 3'd0); r.ill = 1'b0;
      end
      5'b010_10: begin
        off = {24'd0, h[3:2], h[12], h[6:4], 2'b00};
        if (h[11:7] != 5'd0) begin
          r.w = enc_i(off[11:0], 5'd2, 3'd2, h[11:7], 7'h03); r.ill = 1'b0;
        end
      end
      5'b110_10: begin
        off = {24'd0, h[8:7], h[12:9], 2'b00};
        r.w = enc_s(off[11:0], h[6:2], 5'd2, 3'd2, 7'h23); r.ill = 1'b0;
      end
      5'b100_10: begin
        if (h[6:2] == 5'd0 && h[11:7] != 5'd0) begin
          r.w = enc_i(12'd0, h[11:7], 3'd0, h[12] ? 5'd1 : 5'd0, 7'h67); r.ill = 1'b0;
        end
      end
      default: r.ill = 1'b1;
    endcase
    if (r.ill) r.w = '0;
    return r;
  endfunction

  function automatic string tag_of(logic v, logic [31:0] f);
    if (!v) return "R13";
    if (f[1:0] == 2'b11) return "R10";
    case ({f[15:13], f[1:0]})
      5'b000_01: return "R2";
      5'b010_10: return "R3";
      5'b110_10: return "R4";
      5'b010_00, 5'b110_00: return "R5";
      5'b100_01: return "R6";
      5'b001_01, 5'b101_01: return "R7";
      5'b100_10: return "R8";
      5'b110_01, 5'b111_01: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic v, input logic [31:0] f);
    @(negedge clk);
    vld_i = v;
    fetch_i = f;
  endtask

  task automatic check_res(input string tag, input res_t exp);
    res_t act;
    #(CLK_PERIOD/2 - 1);
    act = '{w: instr_o, c: is_comp_o, ill: illegal_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: fetch=%h actual w=%h c=%b ill=%b expected w=%h c=%b ill=%b",
               tag, fetch_i, act.w, act.c, act.ill, exp.w, exp.c, exp.ill);
    end
  endtask

  task automatic run_vec(input logic v, input logic [31:0] f);
    apply(v, f);
    check_res(tag_of(v, f), model(v, f));
  endtask

  task automatic run_dir(input string tag, input logic [31:0] f, input res_t exp);
    apply(1'b1, f);
    check_res(tag, exp);
  endtask

  initial begin
    logic [31:0] ref_w;
    void'($urandom(32'h1c0de));
    // reset state: strobe low, outputs zero (R13)
    repeat (3) @(negedge clk);
    check_res("R13", '0);
    rst_n = 1'b1;

    // R1: short field 100 names x12 (lw x12,0(x12))
    run_dir("R1", 32'h0000_4210, '{w: 32'h0006_2603, c: 1'b1, ill: 1'b0});
    // R2: addi x5,x5,-1 ; zero immediate ; zero register
    run_dir("R2", 32'h0000_12fd, '{w: 32'hfff2_8293, c: 1'b1, ill: 1'b0});
    run_dir("R2", 32'h0000_0281, '{w: 32'h0, c: 1'b1, ill: 1'b1});
    run_dir("R2", 32'h0000_0005, '{w: 32'h0, c: 1'b1, ill: 1'b1});
    // R3: lw x10,252(x2) ; rd zero reserved
    run_dir("R3", 32'h0000_557e, '{w: 32'h0fc1_2503, c: 1'b1, ill: 1'b0});
    run_dir("R3", 32'h0000_4002, '{w: 32'h0, c: 1'b1, ill: 1'b1});
    // R4: sw x1,4(x2)
    run_dir("R4", 32'h0000_c206, '{w: 32'h0011_2223, c: 1'b1, ill: 1'b0});
    // R6: sub x8,x8,x9 and and x15,x15,x8
    run_dir("R6", 32'h0000_8c05, '{w: 32'h4094_0433, c: 1'b1, ill: 1'b0});
    run_dir("R6", 32'h0000_8fe1, '{w: 32'h0087_f7b3, c: 1'b1, ill: 1'b0});
    // R7: jump with offset -2 to x0
    run_dir("R7", 32'h0000_bffd, '{w: 32'hfffff06f, c: 1'b1, ill: 1'b0});
    // R8: jalr x1,0(x5) ; rs1 zero reserved
    run_dir("R8", 32'h0000_9282, '{w: 32'h0002_80e7, c: 1'b1, ill: 1'b0});
    run_dir("R8", 32'h0000_8002, '{w: 32'h0, c: 1'b1, ill: 1'b1});
    // R9: bnez x9, -256
    ref_w = {1'b1, 6'b111000, 5'd0, 5'd9, 3'd1, 4'b0000, 1'b1, 7'h63};
    run_dir("R9", 32'h0000_f081, '{w: ref_w, c: 1'b1, ill: 1'b0});
    // R11: all-zero half ; shift-type pattern unsupported
    run_dir("R11", 32'h0000_0000, '{w: 32'h0, c: 1'b1, ill: 1'b1});
    run_dir("R11", 32'h0000_8005, '{w: 32'h0, c: 1'b1, ill: 1'b1});
    // R10: full-width word
    run_dir("R10", 32'hdead_beef, '{w: 32'hdead_beef, c: 1'b0, ill: 1'b0});
    // R12: upper half noise on a compressed word
    run_dir("R12", 32'h5a5a_557e, '{w: 32'h0fc1_2503, c: 1'b1, ill: 1'b0});
    // R13: strobe low hides a legal word
    apply(1'b0, 32'h0000_557e);
    check_res("R13", '0);

    for (int i = 0; i < N_RAND; i++) begin
      logic [31:0] f;
      f = $urandom();
      if (i % 4 != 3 && f[1:0] == 2'b11) f[1:0] = 2'($urandom_range(0, 2));
      run_vec((i % 17) != 0, f);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYC; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual run unfinished expected finished");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule